// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers six asynchronous interrupt source lines, such as parallel-port bit events and timer outputs, into one interrupt request. Each line passes through a two-flop synchronizer. A rising edge on the synchronized line is an event. When the event's enable bit is set, it sets a sticky bit in a status word. Software sees two registers over a small write/read interface: an enable word it can write, and the status word, which reads back as a plain 6-bit input word.

The request is edge-based on the status word as a whole. It is raised only when the status word leaves the all-zero state. After that, no further request is made until every status bit has been cleared again. There is no clear register. To clear a status bit, software writes 0 to the matching enable bit. A disabled bit always stays at 0, and enabling it again does not bring back events that happened while it was off. By default the request is a one-clock pulse. The parameter `IRQ_LEVEL` instead holds the request high while the status word is non-zero.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the enable word, the status word and `irqOut` are all zero.
- R2: A rising edge on `srcIn[i]` while enable bit i is 1 sets status bit i. The bit is visible on a status read in the cycle after the third rising clock edge that follows the input change. It is not visible after the second.
- R3: A rising edge on a source whose enable bit is 0 leaves the status word unchanged.
- R4: A status bit stays at 1 after its source line returns low.
- R5: With `IRQ_LEVEL`=0, `irqOut` is high for exactly one cycle. That cycle is the first cycle in which the status word is non-zero after being zero.
- R6: While the status word stays non-zero, new events set further bits but produce no further `irqOut` pulse.
- R7: Writing 0 to enable bit i clears status bit i at the same clock edge. Other status bits are left as they were. A status bit is never 1 while its enable bit is 0.
- R8: Enabling a bit again does not set its status bit from events that happened, or levels that stayed high, while it was disabled. Only a new rising edge sets it.
- R9: If an event on source i and a write clearing enable bit i take effect at the same clock edge, the status bit ends at 0 and no pulse is produced.
- R10: Once the status word has returned to zero, the next event produces a new pulse.
- R11: `regAddr`=0 selects the enable word and `regAddr`=1 selects the status word. Bit i of each word belongs to source i. Reads are combinational from the selected word. Writes with `regAddr`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 6 | Asynchronous interrupt source lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 enable, 1 status |
| regWrData | input | 6 | Write data |
| regRdData | output | 6 | Read data of the selected register |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets these cases:
- A second source firing while the status word is already non-zero. A design that fired on any new bit would pulse again.
- A disable write that lands at the same clock edge as an event. A design where the set took priority would leave a stuck bit and a stray pulse.
- A source held high across a disable and re-enable. A level-sensitive or history-keeping design would resurrect the bit.
- The exact synchronizer latency and a status-register write attempt. Wrong pipeline depth would show a bit a cycle early or late, and an unguarded write would change the status word.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int SRC_COUNT = 6;
  localparam int SYNC_STAGES = 2;

  typedef logic [SRC_COUNT-1:0] srcVec_t;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    srcVec_t setMask;   // enabled events this cycle
    srcVec_t keepMask;  // enable word as it will be after this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] edgeOut
);
  logic [WIDTH-1:0] stageQ [STAGES];
  logic [WIDTH-1:0] lastQ;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= rawIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastQ <= '0;
    else       lastQ <= stageQ[STAGES-1];

  assign edgeOut = stageQ[STAGES-1] & ~lastQ;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (edgeOut & $past(edgeOut)) == '0); // R2
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  srcVec_t     srcEdge,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  srcVec_t     regWrData,
  output srcVec_t     enableWord,
  output ctrlStrobe_t strobe
);
  srcVec_t enQ;
  srcVec_t enNext;
  logic    enWrite;

  assign enWrite = regWrEn && (regAddr == 1'b0);
  assign enNext  = enWrite ? regWrData : enQ;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) enQ <= '0;
    else       enQ <= enNext;

  always_comb begin
    strobe.setMask  = srcEdge & enQ;
    strobe.keepMask = enNext;
  end

  assign enableWord = enQ;

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr) |=> enQ == $past(enQ)); // R11
endmodule

// File: rtl/irq_stat_dpath.sv
module irq_stat_dpath
  import irq_stat_pkg::*;
#(
  parameter bit IRQ_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output srcVec_t     statusWord,
  output logic        irqOut
);
  srcVec_t statusQ;
  srcVec_t statusNext;
  logic    irqQ;

  // Disable wins: keepMask is applied after the set
  assign statusNext = (statusQ | strobe.setMask) & strobe.keepMask;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;

  generate
    if (IRQ_LEVEL) begin : g_level
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) irqQ <= 1'b0;
        else       irqQ <= |statusNext;
    end else begin : g_pulse
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) irqQ <= 1'b0;
        else       irqQ <= (statusQ == '0) && (|statusNext);

      AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
        irqQ |=> !irqQ); // R5
      AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
        ((statusQ != '0) && ($past(statusQ) != '0)) |-> !irqQ); // R6
    end
  endgenerate

  assign statusWord = statusQ;
  assign irqOut     = irqQ;

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> statusQ != '0); // R5
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter bit IRQ_LEVEL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcIn,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [SRC_COUNT-1:0] regWrData,
  output logic [SRC_COUNT-1:0] regRdData,
  output logic                 irqOut
);
  srcVec_t     srcEdge;
  srcVec_t     enableWord;
  srcVec_t     statusWord;
  ctrlStrobe_t strobe;

  irq_src_sync #(.WIDTH(SRC_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn(srcIn), .edgeOut(srcEdge)
  );

  irq_stat_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .srcEdge(srcEdge), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .enableWord(enableWord),
    .strobe(strobe)
  );

  irq_stat_dpath #(.IRQ_LEVEL(IRQ_LEVEL)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusWord(statusWord),
    .irqOut(irqOut)
  );

  assign regRdData = regAddr ? statusWord : enableWord;

  AST_DISABLED_IS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~enableWord) == '0); // R7
endmodule

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcIn = '0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [5:0] regWrData = '0;
  logic [5:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0;

  always #10 clk = ~clk;

  irq_status_ctrl dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  always @(negedge clk) if (rstN && irqOut) irqSeen++;

  // {src, doWrite, enableData, expStatus, expPulses}
  localparam int NVEC = 12;
  localparam logic [20:0] VECS [NVEC] = '{
    {6'b000000, 1'b1, 6'b000011, 6'b000000, 2'd0}, // enable bits 0,1
    {6'b000001, 1'b0, 6'b000000, 6'b000001, 2'd1}, // R2 R5
    {6'b000000, 1'b0, 6'b000000, 6'b000001, 2'd0}, // R4
    {6'b000110, 1'b0, 6'b000000, 6'b000011, 2'd0}, // R3 R6
    {6'b000110, 1'b1, 6'b000010, 6'b000010, 2'd0}, // R7
    {6'b000000, 1'b1, 6'b000000, 6'b000000, 2'd0}, // R7
    {6'b000000, 1'b1, 6'b111111, 6'b000000, 2'd0}, // R8
    {6'b100000, 1'b0, 6'b000000, 6'b100000, 2'd1}, // R10
    {6'b110000, 1'b0, 6'b000000, 6'b110000, 2'd0}, // R6
    {6'b110000, 1'b1, 6'b001111, 6'b000000, 2'd0}, // R7
    {6'b000000, 1'b1, 6'b111111, 6'b000000, 2'd0}, // R8
    {6'b001000, 1'b0, 6'b000000, 6'b001000, 2'd1}  // R10
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeEnable(input logic [5:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [5:0] val);
    regAddr = addr;
    #1 val = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    readReg(1'b0, rd); check("R1 enable", rd, 0);
    readReg(1'b1, rd); check("R1 status", rd, 0);
    check("R1 irq", irqOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] e;
      e = VECS[v];
      @(negedge clk);
      irqSeen = 0;
      srcIn = e[20:15];
      if (e[14]) begin
        regWrEn = 1'b1; regAddr = 1'b0; regWrData = e[13:8];
        @(negedge clk);
        regWrEn = 1'b0;
      end
      repeat (5) @(negedge clk);
      readReg(1'b1, rd);
      check($sformatf("R2/R3/R4/R7/R8 vector %0d status", v), rd, e[7:2]);
      check($sformatf("R5/R6/R10 vector %0d pulses", v), irqSeen, e[1:0]);
    end

    // R11: status write ignored, enable readback
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 6'b000000;
    @(negedge clk);
    regWrEn = 1'b0;
    readReg(1'b1, rd); check("R11 status write ignored", rd, 6'b001000);
    readReg(1'b0, rd); check("R11 enable readback", rd, 6'b111111);

    // Clear everything
    srcIn = '0;
    writeEnable(6'b000000);
    writeEnable(6'b111111);
    repeat (4) @(negedge clk);

    // R2: exact latency and pulse timing
    irqSeen = 0;
    srcIn = 6'b000100;
    @(negedge clk); @(negedge clk);
    readReg(1'b1, rd); check("R2 not after second edge", rd, 0);
    @(negedge clk);
    readReg(1'b1, rd); check("R2 set after third edge", rd, 6'b000100);
    check("R5 irq in first non-zero cycle", irqOut, 1);
    @(negedge clk);
    check("R5 irq one cycle", irqOut, 0);

    // clear
    srcIn = '0;
    writeEnable(6'b000000);
    writeEnable(6'b111111);
    repeat (4) @(negedge clk);

    // R9: disable lands on the same edge as the event
    irqSeen = 0;
    srcIn = 6'b010000;
    @(negedge clk); @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 6'b101111;
    @(negedge clk);
    regWrEn = 1'b0;
    readReg(1'b1, rd); check("R9 disable wins status", rd, 0);
    writeEnable(6'b111111);
    repeat (4) @(negedge clk);
    readReg(1'b1, rd); check("R8 held level not resurrected", rd, 0);
    check("R9 no pulse", irqSeen, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule